// File: doc/BRIEF.md
# LFSR Reload Clock Divider Chain

This block produces the divided timing signals that sit around a frequency synthesizer: a reference divider, a feedback divider and a two-stage post divider. All three advance on the system clock. The reference and feedback dividers do not use binary counters. Each one steps a linear feedback shift register (LFSR), and software programs the LFSR state from which counting restarts rather than the divisor. When the register reaches its end state it reloads that state, emits a one-cycle tick and flips a square-wave output. The divisor equals the number of steps from the loaded state to the end state, plus one.

Both LFSRs shift left and feed the inverted parity of their tap bits into bit 0. The all-ones state cannot appear in a plain sequence of this kind, so it serves as the end state. The all-zeros state steps into it. This gives a reference divider that reaches divisor 64 with 6 bits, and a feedback divider that reaches divisor 160 with 8 bits.

The post divider takes a 6-bit control word that holds two 3-bit fields. Each field encodes its stage divisor as eight minus the divisor. Some settings select divide-by-8 in either stage. For these the block first runs with bit 0 of both fields forced high, holds that for a fixed number of cycles, and only then applies the requested value.

Top module: `lfsr_divchain`

## Requirements
- R1: The reference divider is a 6-bit LFSR. Each step shifts left and feeds bit 0 with the inverse of bit5 XOR bit4. State 0x00 steps to 0x3F, and 0x3F is the end state, which reloads the stored code. A code that lies d-1 steps before 0x3F makes ref_tick pulse for one cycle every d cycles, for every d from 1 to 64.
- R2: Reference reload codes 0x3F, 0x00, 0x20, 0x10 and 0x01 give divisors 1, 2, 3, 4 and 64.
- R3: The feedback divider is an 8-bit LFSR with the same structure. Bit 0 is fed with the inverse of bit7 XOR bit3 XOR bit2 XOR bit1, and the end state is 0xFF. Codes 0x00, 0x80, 0xC0, 0xE0 and 0x69 give divisors 2, 3, 4, 5 and 160, and every divisor from 2 to 160 is reachable.
- R4: ref_clk flips in exactly the cycles where ref_tick is high and holds otherwise, and likewise fb_clk with fb_tick. A divisor d therefore gives a square wave with a period of 2d cycles.
- R5: A code write takes effect at the first reload whose edge comes after the write's edge. A write sampled on the same edge as a reload leaves that reload with the previous code. A write one edge earlier shapes the very next interval.
- R6: Post divisor 1 is 8 minus post_ctrl[2:0] and post divisor 2 is 8 minus post_ctrl[5:3]. Each ranges over 1 to 8. Once settled, post_tick pulses once every product of the two divisors. Each stage adopts a new divisor only when it wraps.
- R7: A post_ctrl write with either field equal to 0 first runs with the value ORed with 0x09 for PREP_CYCLES cycles, then switches to the written value. Any other write applies directly.
- R8: While rst is high all outputs are 0. After release, all dividers run at divisor 1: every tick is high on each cycle, and both square waves flip on every cycle starting at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock driving all dividers |
| rst | input | 1 | Synchronous active-high reset |
| ref_wr | input | 1 | Load ref_code as the reference reload state |
| ref_code | input | REF_W | Reference reload state |
| fb_wr | input | 1 | Load fb_code as the feedback reload state |
| fb_code | input | FB_W | Feedback reload state |
| post_wr | input | 1 | Load post_ctrl |
| post_ctrl | input | POST_STAGES*POST_FW | Encoded post divider setting |
| ref_tick | output | 1 | One-cycle pulse at each reference reload |
| ref_clk | output | 1 | Reference square wave |
| fb_tick | output | 1 | One-cycle pulse at each feedback reload |
| fb_clk | output | 1 | Feedback square wave |
| post_tick | output | 1 | One-cycle pulse once per post divider period |

## Verification
The critical coincidence is a code write landing on the same edge as the end-state reload. The bench locks onto a tick of a known divisor and times the write to land exactly on the next reload edge, then one edge earlier. It judges each case by the lengths of the two following tick intervals. A second overlap is a post_ctrl write that starts the hold sequence while both stages are partway through a period. The bench measures the interim ratio inside the hold window and the final ratio after it.

// File: rtl/lfsr_divchain_pkg.sv
package lfsr_divchain_pkg;

  typedef enum logic [0:0] {
    SEQ_RUN  = 1'b0,
    SEQ_HOLD = 1'b1
  } seq_state_e;

  // Mask with the lowest bit of every stage field set.
  function automatic logic [31:0] stage_lsb_mask(input int stages, input int fw);
    logic [31:0] m;
    m = '0;
    for (int s = 0; s < stages; s++) begin
      m[s*fw] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/lfsr_reload_div.sv
module lfsr_reload_div #(
  parameter int             W    = 6,
  parameter logic [W-1:0]   TAPS = 6'h30
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  logic [W-1:0] code,
  output logic         tick,
  output logic         clk_out
);

  localparam logic [W-1:0] END_STATE = '1;
  localparam logic [W-1:0] ZERO      = '0;

  logic [W-1:0] state_q;
  logic [W-1:0] reload_q;
  logic [W-1:0] step;
  logic         at_end;

  // Shift left, XNOR feedback; the all-zero state jumps to the end state.
  always_comb begin
    if (state_q == ZERO) begin
      step = END_STATE;
    end else begin
      step = {state_q[W-2:0], ~(^(state_q & TAPS))};
    end
  end

  assign at_end = (state_q == END_STATE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= END_STATE;
      reload_q <= END_STATE;
      tick     <= 1'b0;
      clk_out  <= 1'b0;
    end else begin
      if (wr) begin
        reload_q <= code;
      end
      if (at_end) begin
        state_q <= reload_q;
        clk_out <= ~clk_out;
      end else begin
        state_q <= step;
      end
      tick <= at_end;
    end
  end

endmodule

// File: rtl/postdiv_stage.sv
module postdiv_stage #(
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  input  logic [DW-1:0] div_in,
  output logic          wrap
);

  logic [DW-1:0] cnt_q;
  logic [DW-1:0] act_q;

  assign wrap = adv && ((cnt_q + DW'(1)) == act_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      act_q <= DW'(1);
    end else if (wrap) begin
      cnt_q <= '0;
      act_q <= div_in;
    end else if (adv) begin
      cnt_q <= cnt_q + DW'(1);
    end
  end

endmodule

// File: rtl/postdiv_seq.sv
module postdiv_seq
  import lfsr_divchain_pkg::*;
#(
  parameter int STAGES      = 2,
  parameter int FW          = 3,
  parameter int PREP_CYCLES = 256,
  localparam int CW         = STAGES * FW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [CW-1:0] ctrl_in,
  output logic [CW-1:0] ctrl_eff
);

  localparam int          PCW  = $clog2(PREP_CYCLES + 1);
  localparam logic [31:0] MASK32 = stage_lsb_mask(STAGES, FW);
  localparam logic [CW-1:0] MASK = MASK32[CW-1:0];

  seq_state_e      state_q;
  logic [CW-1:0]   final_q;
  logic [PCW-1:0]  hold_q;
  logic [STAGES-1:0] field_max;
  logic            needs_hold;

  for (genvar s = 0; s < STAGES; s++) begin : g_fld
    assign field_max[s] = (ctrl_in[s*FW +: FW] == '0);
  end

  assign needs_hold = |field_max;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= SEQ_RUN;
      ctrl_eff <= '1;
      final_q  <= '1;
      hold_q   <= '0;
    end else if (wr) begin
      if (needs_hold) begin
        ctrl_eff <= ctrl_in | MASK;
        final_q  <= ctrl_in;
        hold_q   <= PCW'(PREP_CYCLES - 1);
        state_q  <= SEQ_HOLD;
      end else begin
        ctrl_eff <= ctrl_in;
        state_q  <= SEQ_RUN;
      end
    end else if (state_q == SEQ_HOLD) begin
      if (hold_q == '0) begin
        ctrl_eff <= final_q;
        state_q  <= SEQ_RUN;
      end else begin
        hold_q <= hold_q - PCW'(1);
      end
    end
  end

endmodule

// File: rtl/lfsr_divchain.sv
module lfsr_divchain #(
  parameter int                REF_W       = 6,
  parameter logic [REF_W-1:0]  REF_TAPS    = 6'h30,
  parameter int                FB_W        = 8,
  parameter logic [FB_W-1:0]   FB_TAPS     = 8'h8E,
  parameter int                POST_STAGES = 2,
  parameter int                POST_FW     = 3,
  parameter int                PREP_CYCLES = 256
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           ref_wr,
  input  logic [REF_W-1:0]               ref_code,
  input  logic                           fb_wr,
  input  logic [FB_W-1:0]                fb_code,
  input  logic                           post_wr,
  input  logic [POST_STAGES*POST_FW-1:0] post_ctrl,
  output logic                           ref_tick,
  output logic                           ref_clk,
  output logic                           fb_tick,
  output logic                           fb_clk,
  output logic                           post_tick
);

  localparam int CW = POST_STAGES * POST_FW;
  localparam int DW = POST_FW + 1;
  localparam logic [DW-1:0] FIELD_SPAN = DW'(2 ** POST_FW);

  lfsr_reload_div #(.W(REF_W), .TAPS(REF_TAPS)) u_ref (
    .clk     (clk),
    .rst     (rst),
    .wr      (ref_wr),
    .code    (ref_code),
    .tick    (ref_tick),
    .clk_out (ref_clk)
  );

  lfsr_reload_div #(.W(FB_W), .TAPS(FB_TAPS)) u_fb (
    .clk     (clk),
    .rst     (rst),
    .wr      (fb_wr),
    .code    (fb_code),
    .tick    (fb_tick),
    .clk_out (fb_clk)
  );

  logic [CW-1:0]          ctrl_eff;
  logic [POST_STAGES:0]   adv;

  postdiv_seq #(
    .STAGES      (POST_STAGES),
    .FW          (POST_FW),
    .PREP_CYCLES (PREP_CYCLES)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .wr       (post_wr),
    .ctrl_in  (post_ctrl),
    .ctrl_eff (ctrl_eff)
  );

  assign adv[0] = 1'b1;

  for (genvar s = 0; s < POST_STAGES; s++) begin : g_post
    logic [DW-1:0] div_s;
    assign div_s = FIELD_SPAN - {1'b0, ctrl_eff[s*POST_FW +: POST_FW]};

    postdiv_stage #(.DW(DW)) u_stage (
      .clk    (clk),
      .rst    (rst),
      .adv    (adv[s]),
      .div_in (div_s),
      .wrap   (adv[s+1])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      post_tick <= 1'b0;
    end else begin
      post_tick <= adv[POST_STAGES];
    end
  end

endmodule

// File: rtl/lfsr_divchain_chk.sv
module lfsr_divchain_chk #(
  parameter int REF_W      = 6,
  parameter int FB_W       = 8,
  parameter int POST_LIMIT = 64
) (
  input logic clk,
  input logic rst,
  input logic ref_tick,
  input logic ref_clk,
  input logic fb_tick,
  input logic fb_clk,
  input logic post_tick
);

  int ref_gap;
  int fb_gap;
  int post_gap;

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_gap  <= 0;
      fb_gap   <= 0;
      post_gap <= 0;
    end else begin
      ref_gap  <= ref_tick  ? 0 : ref_gap + 1;
      fb_gap   <= fb_tick   ? 0 : fb_gap + 1;
      post_gap <= post_tick ? 0 : post_gap + 1;
    end
  end

  AST_REF_FLIP_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    ref_tick |-> (ref_clk != $past(ref_clk)));  // R4
  AST_REF_HOLD_OFF_TICK: assert property (@(posedge clk) disable iff (rst)
    !ref_tick |-> $stable(ref_clk));  // R4
  AST_FB_FLIP_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    fb_tick |-> (fb_clk != $past(fb_clk)));  // R4
  AST_FB_HOLD_OFF_TICK: assert property (@(posedge clk) disable iff (rst)
    !fb_tick |-> $stable(fb_clk));  // R4
  AST_REF_GAP_BOUND: assert property (@(posedge clk) disable iff (rst)
    ref_gap < (1 << REF_W));  // R1
  AST_FB_GAP_BOUND: assert property (@(posedge clk) disable iff (rst)
    fb_gap < (1 << FB_W));  // R3
  AST_POST_GAP_BOUND: assert property (@(posedge clk) disable iff (rst)
    post_gap < POST_LIMIT);  // R6

endmodule

bind lfsr_divchain lfsr_divchain_chk #(
  .REF_W      (REF_W),
  .FB_W       (FB_W),
  .POST_LIMIT (1 << (POST_FW * POST_STAGES))
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ref_tick  (ref_tick),
  .ref_clk   (ref_clk),
  .fb_tick   (fb_tick),
  .fb_clk    (fb_clk),
  .post_tick (post_tick)
);

// File: tb/lfsr_divchain_tb_top.sv
`timescale 1ns/1ps
module lfsr_divchain_tb_top;

  localparam int PREP = 400;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ref_wr = 1'b0;
  logic [5:0] ref_code = '0;
  logic       fb_wr = 1'b0;
  logic [7:0] fb_code = '0;
  logic       post_wr = 1'b0;
  logic [5:0] post_ctrl = '0;
  logic       ref_tick, ref_clk, fb_tick, fb_clk, post_tick;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;

  lfsr_divchain #(.PREP_CYCLES(PREP)) dut_i (
    .clk       (clk),
    .rst       (rst),
    .ref_wr    (ref_wr),
    .ref_code  (ref_code),
    .fb_wr     (fb_wr),
    .fb_code   (fb_code),
    .post_wr   (post_wr),
    .post_ctrl (post_ctrl),
    .ref_tick  (ref_tick),
    .ref_clk   (ref_clk),
    .fb_tick   (fb_tick),
    .fb_clk    (fb_clk),
    .post_tick (post_tick)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic tick_of(input int w);
    case (w)
      0:       return ref_tick;
      1:       return fb_tick;
      default: return post_tick;
    endcase
  endfunction

  function automatic logic clk_of(input int w);
    return (w == 0) ? ref_clk : fb_clk;
  endfunction

  // Walk backwards from the all-ones end state d-1 steps (R1, R3).
  function automatic int lfsr_code(input int w, input int taps, input int d);
    int all_ones;
    int s;
    all_ones = (1 << w) - 1;
    s = all_ones;
    for (int i = 1; i < d; i++) begin
      if (s == all_ones) begin
        s = 0;
      end else begin
        int low;
        int par;
        int msb;
        low = s >> 1;
        par = ^(low & taps & (all_ones >> 1));
        msb = 1 ^ (s & 1) ^ par;
        s = (msb << (w - 1)) | low;
      end
    end
    return s;
  endfunction

  function automatic int post_ratio(input int c);
    return (8 - (c & 7)) * (8 - ((c >> 3) & 7));
  endfunction

  task automatic wait_tick(input int w);
    int g;
    g = 0;
    do begin
      @(negedge clk);
      g++;
    end while (!tick_of(w) && g < 4000);
  endtask

  task automatic measure(input int w, output int per, output int flipped);
    logic c0;
    wait_tick(w);
    c0 = clk_of(w);
    per = 0;
    do begin
      @(negedge clk);
      per++;
    end while (!tick_of(w) && per < 4000);
    flipped = (clk_of(w) != c0) ? 1 : 0;
  endtask

  task automatic settle(input int w);
    wait_tick(w);
    wait_tick(w);
  endtask

  task automatic write_ref(input int c);
    ref_code = 6'(c);
    ref_wr = 1'b1;
    @(negedge clk);
    ref_wr = 1'b0;
  endtask

  task automatic write_fb(input int c);
    fb_code = 8'(c);
    fb_wr = 1'b1;
    @(negedge clk);
    fb_wr = 1'b0;
  endtask

  task automatic write_post(input int c);
    post_ctrl = 6'(c);
    post_wr = 1'b1;
    @(negedge clk);
    post_wr = 1'b0;
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual still running, expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    int per;
    int fl;
    int rc [5] = '{'h3F, 'h00, 'h20, 'h10, 'h01};
    int rd [5] = '{1, 2, 3, 4, 64};
    int fc [5] = '{'h00, 'h80, 'hC0, 'hE0, 'h69};
    int fd [5] = '{2, 3, 4, 5, 160};
    void'($urandom(32'd20240611));

    // R8: reset state and divide-by-1 start
    repeat (4) @(negedge clk);
    check("R8 outputs in reset", int'({ref_tick, ref_clk, fb_tick, fb_clk, post_tick}), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R8 first cycle", int'({ref_tick, ref_clk, fb_tick, fb_clk, post_tick}), 'h1F);
    @(negedge clk);
    check("R8 second cycle", int'({ref_tick, ref_clk, fb_tick, fb_clk, post_tick}), 'h15);

    // R2: listed reference codes
    for (int i = 0; i < 5; i++) begin
      write_ref(rc[i]);
      settle(0);
      measure(0, per, fl);
      check("R2 ref code ratio", per, rd[i]);
    end

    // R1 and R4: every reference divisor
    for (int d = 1; d <= 64; d++) begin
      write_ref(lfsr_code(6, 'h30, d));
      settle(0);
      measure(0, per, fl);
      check("R1 ref ratio", per, d);
      check("R4 ref_clk flip", fl, 1);
    end

    // R3: listed feedback codes
    for (int i = 0; i < 5; i++) begin
      write_fb(fc[i]);
      settle(1);
      measure(1, per, fl);
      check("R3 fb code ratio", per, fd[i]);
    end

    // R3 and R4: every feedback divisor
    for (int d = 2; d <= 160; d++) begin
      write_fb(lfsr_code(8, 'h8E, d));
      settle(1);
      measure(1, per, fl);
      check("R3 fb ratio", per, d);
      check("R4 fb_clk flip", fl, 1);
    end

    // R5 case A: write lands on the reload edge, so one more old interval
    write_ref(lfsr_code(6, 'h30, 10));
    settle(0);
    wait_tick(0);
    repeat (9) @(negedge clk);
    write_ref(lfsr_code(6, 'h30, 5));
    check("R5 tick on reload edge", int'(ref_tick), 1);
    per = 0;
    do begin @(negedge clk); per++; end while (!ref_tick && per < 4000);
    check("R5 same-edge write keeps old", per, 10);
    per = 0;
    do begin @(negedge clk); per++; end while (!ref_tick && per < 4000);
    check("R5 new code after next reload", per, 5);

    // R5 case B: write one edge before reload applies to the next interval
    write_ref(lfsr_code(6, 'h30, 10));
    settle(0);
    wait_tick(0);
    repeat (8) @(negedge clk);
    write_ref(lfsr_code(6, 'h30, 5));
    wait_tick(0);
    per = 0;
    do begin @(negedge clk); per++; end while (!ref_tick && per < 4000);
    check("R5 early write applies at once", per, 5);

    // R6: every post control word
    for (int c = 0; c < 64; c++) begin
      write_post(c);
      if ((c & 7) == 0 || ((c >> 3) & 7) == 0) begin
        repeat (PREP + 20) @(negedge clk);
      end
      settle(2);
      measure(2, per, fl);
      check("R6 post ratio", per, post_ratio(c));
    end

    // R7: hold value inside the window, final value after it
    write_post('h3F);
    settle(2);
    write_post('h00);
    settle(2);
    measure(2, per, fl);
    check("R7 hold ratio for 0x00", per, 49);
    repeat (PREP) @(negedge clk);
    settle(2);
    measure(2, per, fl);
    check("R7 final ratio for 0x00", per, 64);

    write_post('h3F);
    settle(2);
    write_post('h38);
    settle(2);
    measure(2, per, fl);
    check("R7 hold ratio for 0x38", per, 7);
    repeat (PREP) @(negedge clk);
    settle(2);
    measure(2, per, fl);
    check("R7 final ratio for 0x38", per, 8);

    // Random mixes of all three dividers (R1, R3, R6)
    for (int it = 0; it < 20; it++) begin
      int dr;
      int df;
      int pc;
      dr = int'($urandom_range(64, 1));
      df = int'($urandom_range(160, 2));
      pc = (int'($urandom_range(7, 1)) << 3) | int'($urandom_range(7, 1));
      write_ref(lfsr_code(6, 'h30, dr));
      write_fb(lfsr_code(8, 'h8E, df));
      write_post(pc);
      settle(0);
      measure(0, per, fl);
      check("R1 random ref", per, dr);
      settle(1);
      measure(1, per, fl);
      check("R3 random fb", per, df);
      settle(2);
      measure(2, per, fl);
      check("R6 random post", per, post_ratio(pc));
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule